// File: doc/BRIEF.md
# Sticky Interrupt Status Collector

This block gathers interrupt causes into a 32-bit sticky status word. Causes arrive from two places: internal hardware sources, which each give a one-cycle request, and software, which writes a bit mask to a raise offset. A set bit stays set until software writes a mask to an acknowledge offset. Software reads the whole word at a status offset.

The block drives one of two interrupt outputs, chosen by a mode input. In level mode a line goes high when a raise leaves the status nonzero. It goes low only when an acknowledge leaves the status at zero. In message mode every raise that leaves the status nonzero gives a one-cycle strobe, which a message transport outside this block turns into a message. In that mode the level line keeps its value. The message transport and any configuration space are not part of this block.

Top module: `irq_collect`

## Requirements
- R1: After a synchronous active-low reset, the status is zero, `irq_level` is low and `msg_strobe` is low.
- R2: `rd_data` returns the status word when `rd_addr` is 0x24. It returns zero for any other address.
- R3: A write to offset 0x60 ORs `wr_data` into the status. The result is visible on `rd_data` after the clock edge that takes the write.
- R4: A write to offset 0x64 clears each status bit whose `wr_data` bit is 1 and leaves the other bits unchanged.
- R5: Hardware request `hw_req[i]` sets status bit `i*SRC_STRIDE`. With the defaults, `hw_req[0]` (factorial done) sets bit 0 and `hw_req[1]` (DMA done) sets bit 8. A write to any offset other than 0x60 or 0x64 does not change the status.
- R6: When a set (from hardware or a raise write) and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R7: With `msg_mode` low, `irq_level` goes high at the edge after any raise (a raise write or any `hw_req` bit) that leaves the status nonzero.
- R8: With `msg_mode` low, `irq_level` goes low only at the edge after an acknowledge that leaves the status at zero. A partial acknowledge keeps it high. A zero-mask raise also keeps it high.
- R9: With `msg_mode` high, `msg_strobe` is high for exactly the one cycle after each raise cycle whose result is nonzero. Raises in back-to-back cycles give back-to-back strobes, one for each raise. With `msg_mode` low, `msg_strobe` stays low.
- R10: An acknowledge alone never causes a strobe. A zero-mask raise while the status is zero causes neither a strobe nor a rise of `irq_level`.
- R11: With `msg_mode` high, `irq_level` keeps its previous value whatever raises or acknowledges occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_mode | input | 1 | 1 selects the message strobe output, 0 selects the level line |
| hw_req | input | NUM_SRC | One-cycle set requests from the hardware sources |
| wr_en | input | 1 | Software write strobe |
| wr_addr | input | ADDR_W | Software write offset |
| wr_data | input | STAT_W | Software write mask |
| rd_addr | input | ADDR_W | Software read offset |
| rd_data | output | STAT_W | Read data, combinational from the status register |
| irq_level | output | 1 | Level interrupt line |
| msg_strobe | output | 1 | One-cycle request to the message transport |

## Verification
A walking single bit is raised and then acknowledged in level mode. This shows that every status bit is stored, cleared on its own, and tied to the rise and fall of the line. A sweep of 64 mixed cycles pairs varied masks with raise and acknowledge writes, hardware requests and both modes. A bench model computes the expected status, line and strobe, which exposes wrong set/clear priority and wrong mode gating. Directed cases cover the remaining corners: a set and a clear on the same bit in one cycle, a partial acknowledge, zero-mask raises, back-to-back raises in message mode, and reads from addresses that are not decoded.

// File: rtl/irq_collect_pkg.sv
// Package: shared offsets and widths for the interrupt status collector.
// Assumes one software write port; offsets are byte offsets within the block.
package irq_collect_pkg;
    localparam int unsigned STAT_W_DEF = 32;
    localparam int unsigned ADDR_W_DEF = 8;
    localparam logic [7:0] OFS_STATUS = 8'h24;
    localparam logic [7:0] OFS_RAISE  = 8'h60;
    localparam logic [7:0] OFS_ACK    = 8'h64;

    // Decoded software operation for one cycle.
    typedef enum logic [1:0] {
        SW_NONE  = 2'd0,
        SW_RAISE = 2'd1,
        SW_ACK   = 2'd2
    } sw_op_e;
endpackage

// File: rtl/irq_req_decode.sv
// Request decoder: turns software writes and hardware requests into a set
// mask, a clear mask and raise/ack operation flags for the current cycle.
// Assumes hardware source i maps to status bit i*SRC_STRIDE, inside STAT_W.
module irq_req_decode
    import irq_collect_pkg::*;
#(
    parameter int unsigned STAT_W     = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_SRC    = 2,
    parameter int unsigned SRC_STRIDE = 8
) (
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [STAT_W-1:0]  wr_data,
    output logic [STAT_W-1:0]  set_mask,
    output logic [STAT_W-1:0]  clr_mask,
    output logic               raise_op,
    output logic               ack_op
);
    localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFS_RAISE);
    localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);

    sw_op_e              sw_op;
    logic [STAT_W-1:0]   hw_mask;

    // Classify the software write of this cycle.
    always_comb begin
        sw_op = SW_NONE;
        if (wr_en && wr_addr == A_RAISE) sw_op = SW_RAISE;
        else if (wr_en && wr_addr == A_ACK) sw_op = SW_ACK;
    end

    // Place each hardware request on its own status bit.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int unsigned BITPOS = i * SRC_STRIDE;
        always_comb begin
            hw_mask[BITPOS] = hw_req[i];
        end
    end

    // Bits that no source owns are never set by hardware.
    for (genvar b = 0; b < STAT_W; b++) begin : g_fill
        if ((b % SRC_STRIDE) != 0 || (b / SRC_STRIDE) >= NUM_SRC) begin : g_zero
            always_comb begin
                hw_mask[b] = 1'b0;
            end
        end
    end

    // Combine both origins into the masks and operation flags.
    always_comb begin
        set_mask = hw_mask | ((sw_op == SW_RAISE) ? wr_data : '0);
        clr_mask = (sw_op == SW_ACK) ? wr_data : '0;
        raise_op = (sw_op == SW_RAISE) || (|hw_req);
        ack_op   = (sw_op == SW_ACK);
    end
endmodule

// File: rtl/irq_stat_reg.sv
// Sticky status register: clears first, then sets, so a set wins over a
// clear on the same bit. Also reports whether the next value is nonzero.
// Assumes synchronous active-low reset.
module irq_stat_reg #(
    parameter int unsigned STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_mask,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] status_q,
    output logic              next_nz
);
    logic [STAT_W-1:0] status_d;

    // Next value: clear applied before set.
    always_comb begin
        status_d = (status_q & ~clr_mask) | set_mask;
        next_nz  = |status_d;
    end

    // Hold the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end
endmodule

// File: rtl/irq_out_gen.sv
// Output generator: keeps the level line and produces the message strobe.
// Assumes raise_op/ack_op/next_nz describe the update taken at this edge.
module irq_out_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic msg_mode,
    input  logic raise_op,
    input  logic ack_op,
    input  logic next_nz,
    output logic irq_level,
    output logic msg_strobe
);
    // Level line: rises on a raise leaving nonzero, falls on an ack leaving zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level <= 1'b0;
        end else if (!msg_mode) begin
            if (raise_op && next_nz)     irq_level <= 1'b1;
            else if (ack_op && !next_nz) irq_level <= 1'b0;
        end
    end

    // Message strobe: one cycle for every raise cycle leaving nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n) msg_strobe <= 1'b0;
        else        msg_strobe <= msg_mode && raise_op && next_nz;
    end
endmodule

// File: rtl/irq_collect.sv
// Top: sticky interrupt status collector. Software raises and acknowledges
// through two write offsets and reads the word at a third. Hardware sources
// give one-cycle requests. Output is a level line or a message strobe.
// Assumes synchronous active-low reset and a single clock.
module irq_collect
    import irq_collect_pkg::*;
#(
    parameter int unsigned STAT_W     = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_SRC    = 2,
    parameter int unsigned SRC_STRIDE = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msg_mode,
    input  logic [NUM_SRC-1:0] hw_req,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [STAT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [STAT_W-1:0]  rd_data,
    output logic               irq_level,
    output logic               msg_strobe
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

    logic [STAT_W-1:0] set_mask;
    logic [STAT_W-1:0] clr_mask;
    logic [STAT_W-1:0] status_q;
    logic              raise_op;
    logic              ack_op;
    logic              next_nz;

    irq_req_decode #(
        .STAT_W(STAT_W), .ADDR_W(ADDR_W),
        .NUM_SRC(NUM_SRC), .SRC_STRIDE(SRC_STRIDE)
    ) u_dec (
        .hw_req(hw_req), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .set_mask(set_mask), .clr_mask(clr_mask),
        .raise_op(raise_op), .ack_op(ack_op)
    );

    irq_stat_reg #(.STAT_W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n),
        .set_mask(set_mask), .clr_mask(clr_mask),
        .status_q(status_q), .next_nz(next_nz)
    );

    irq_out_gen u_out (
        .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode),
        .raise_op(raise_op), .ack_op(ack_op), .next_nz(next_nz),
        .irq_level(irq_level), .msg_strobe(msg_strobe)
    );

    // Read mux: only the status offset returns data.
    always_comb begin
        rd_data = (rd_addr == A_STATUS) ? status_q : '0;
    end
endmodule

// File: rtl/irq_collect_chk.sv
// Checker: temporal properties of the collector, bound to the top module.
// Assumes default source mapping (bit 0 and bit SRC_STRIDE).
module irq_collect_chk
    import irq_collect_pkg::*;
#(
    parameter int unsigned STAT_W     = 32,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_SRC    = 2,
    parameter int unsigned SRC_STRIDE = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               msg_mode,
    input logic [NUM_SRC-1:0] hw_req,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [STAT_W-1:0]  wr_data,
    input logic [STAT_W-1:0]  status_q,
    input logic               irq_level,
    input logic               msg_strobe
);
    localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFS_RAISE);
    localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);

    logic ack_w, raise_w;
    assign ack_w   = wr_en && wr_addr == A_ACK;
    assign raise_w = wr_en && wr_addr == A_RAISE;

    AST_HW_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_req[0] |=> status_q[0]); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_w && hw_req == '0) |=> ((status_q & $past(wr_data)) == '0)); // R4

    AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        raise_w |=> ((status_q & $past(wr_data)) == $past(wr_data))); // R3

    AST_NO_STROBE_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_w && hw_req == '0) |=> !msg_strobe); // R10

    AST_STROBE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_mode |=> !msg_strobe); // R9

    AST_LEVEL_HOLD_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        msg_mode |=> $stable(irq_level)); // R11

    AST_LEVEL_FALL_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_level) |-> ($past(ack_w) && status_q == '0)); // R8
endmodule

bind irq_collect irq_collect_chk #(
    .STAT_W(STAT_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .SRC_STRIDE(SRC_STRIDE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .hw_req(hw_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .status_q(status_q), .irq_level(irq_level), .msg_strobe(msg_strobe)
);

// File: tb/irq_collect_tb.sv
// Bench: walking-bit sweep, mixed-pattern sweep and directed corners,
// compared against expected values computed from the requirements.
module irq_collect_tb;
    localparam logic [7:0] A_STAT  = 8'h24;
    localparam logic [7:0] A_RAISE = 8'h60;
    localparam logic [7:0] A_ACK   = 8'h64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_mode = 1'b0;
    logic [1:0]  hw_req = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = A_STAT;
    logic [31:0] rd_data;
    logic        irq_level;
    logic        msg_strobe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_stat = '0;
    logic        m_lvl = 1'b0;
    logic        m_stb = 1'b0;

    always #5 clk = ~clk;

    irq_collect u_dut (
        .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .hw_req(hw_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_level(irq_level), .msg_strobe(msg_strobe)
    );

    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, update model, check at next negedge.
    task automatic step(input string tag, input logic mode, input logic [1:0] hw,
                        input logic we, input logic [7:0] addr, input logic [31:0] data);
        logic [31:0] setm, clrm, nxt;
        logic raise, ack;
        msg_mode = mode; hw_req = hw; wr_en = we; wr_addr = addr; wr_data = data;
        setm  = ((we && addr == A_RAISE) ? data : 32'h0) | {23'h0, hw[1], 7'h0, hw[0]};
        clrm  = (we && addr == A_ACK) ? data : 32'h0;
        raise = (we && addr == A_RAISE) || (hw != 2'b00);
        ack   = we && addr == A_ACK;
        nxt   = (m_stat & ~clrm) | setm;
        if (!mode) begin
            if (raise && nxt != 0)     m_lvl = 1'b1;
            else if (ack && nxt == 0)  m_lvl = 1'b0;
        end
        m_stb  = mode && raise && (nxt != 0);
        m_stat = nxt;
        @(negedge clk);
        hw_req = '0; wr_en = 1'b0;
        chk32({tag, " status"}, rd_data, m_stat);
        chk32({tag, " level"}, {31'h0, irq_level}, {31'h0, m_lvl});
        chk32({tag, " strobe"}, {31'h0, msg_strobe}, {31'h0, m_stb});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk32("R1 status", rd_data, 32'h0);
        chk32("R1 level", {31'h0, irq_level}, 32'h0);
        chk32("R1 strobe", {31'h0, msg_strobe}, 32'h0);
        rst_n = 1'b1;

        // R3 R4 R7 R8: walking bit raised then acknowledged, level mode
        for (int b = 0; b < 32; b++) begin
            step("R3 R7 walk raise", 1'b0, 2'b00, 1'b1, A_RAISE, 32'h1 << b);
            step("R4 R8 walk ack", 1'b0, 2'b00, 1'b1, A_ACK, 32'h1 << b);
        end

        // R5: hardware sources map to bits 0 and 8; other offsets ignored
        step("R5 hw fact", 1'b0, 2'b01, 1'b0, 8'h00, 32'h0);
        step("R5 hw dma", 1'b0, 2'b10, 1'b0, 8'h00, 32'h0);
        step("R5 other offset write", 1'b0, 2'b00, 1'b1, 8'h68, 32'hFFFF_FFFF);
        // R2: other read address returns zero, status address returns word
        rd_addr = 8'h20; #1;
        chk32("R2 undecoded read", rd_data, 32'h0);
        rd_addr = A_STAT; #1;
        chk32("R2 status read", rd_data, 32'h0000_0101);
        // R8: partial ack keeps line; zero raise keeps line
        step("R8 partial ack", 1'b0, 2'b00, 1'b1, A_ACK, 32'h0000_0001);
        step("R8 zero raise", 1'b0, 2'b00, 1'b1, A_RAISE, 32'h0);
        step("R8 final ack", 1'b0, 2'b00, 1'b1, A_ACK, 32'h0000_0100);
        // R6: set and clear on same bits in one cycle
        step("R6 set wins", 1'b0, 2'b11, 1'b1, A_ACK, 32'hFFFF_FFFF);
        step("R6 clear after", 1'b0, 2'b00, 1'b1, A_ACK, 32'hFFFF_FFFF);
        // R10: zero raise with zero status
        step("R10 zero raise lvl", 1'b0, 2'b00, 1'b1, A_RAISE, 32'h0);
        step("R10 zero raise msg", 1'b1, 2'b00, 1'b1, A_RAISE, 32'h0);
        // R9: back-to-back raises give back-to-back strobes
        step("R9 raise a", 1'b1, 2'b00, 1'b1, A_RAISE, 32'h0000_0010);
        step("R9 raise b", 1'b1, 2'b01, 1'b0, 8'h00, 32'h0);
        step("R9 gap", 1'b1, 2'b00, 1'b0, 8'h00, 32'h0);
        // R10 R11: ack in message mode, no strobe, level held low
        step("R10 R11 ack msg", 1'b1, 2'b00, 1'b1, A_ACK, 32'hFFFF_FFFF);
        step("R11 lvl raise", 1'b0, 2'b00, 1'b1, A_RAISE, 32'h8000_0000);
        step("R11 msg ack holds", 1'b1, 2'b00, 1'b1, A_ACK, 32'h8000_0000);

        // R6 R9 R11: mixed-pattern sweep with both modes and sources
        for (int i = 0; i < 64; i++) begin
            logic [31:0] d;
            d = 32'(i) * 32'h9E37_79B1;
            step("R6 R9 R11 sweep", i[3], 2'(i % 4), 1'b1,
                 (i % 3 == 0) ? A_ACK : A_RAISE, (i % 5 == 0) ? 32'h0 : d);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule